// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block holds the 16-bit power-management control word of a system controller and turns software writes to it into sleep requests. Software reaches it through a small register window: the word lives at byte offsets 4 and 5 of the window, and each write carries two byte-lane enables, so one access can change the low byte, the high byte, or both. Reads show the stored word with its write-only bits forced to zero.

A 3-bit sleep-type field sits in bits 12:10, and bit 13 is the sleep-enable trigger. The block never stores bit 13. When a write that covers the high byte sets it, the block decodes the sleep type. It then raises single-cycle requests on the clock after the write: a system-reset request together with a suspend-resume flag for suspend-to-RAM, or a shutdown request for the hibernate and soft-off types. The register port has no data stream, so its pins are plain strobes with no back-pressure. A write completes in the cycle it is presented, and read data is combinational on the offset.

Top module: `pm1_ctl_reg`

## Requirements
- R1: After reset the word reads 0x0001, with only bit 0 (SCI enable) set, and no request output is high.
- R2: A write at offset 4 or 5 with both lane enables set (`wr_be` = 2'b11) stores all 16 bits except bit 13, which is always stored as 0.
- R3: Lane enable `wr_be[0]` updates only bits 7:0 and `wr_be[1]` updates only bits 15:8. The other byte keeps its value.
- R4: Read data at offset 4 or 5 is the stored word with bit 2 (global-lock release) and bit 13 (sleep enable) returned as 0. Bit 2 is still stored.
- R5: A write with `wr_be[1]` set, `wr_data[13]` = 1 and `wr_data[12:10]` = 5 raises `sys_reset_req` and `s3_resume_flag` for exactly the one cycle after the write, and leaves `shutdown_req` low.
- R6: A write with `wr_be[1]` set, `wr_data[13]` = 1 and `wr_data[12:10]` = 6 or 7 raises `shutdown_req` for exactly the one cycle after the write. `sys_reset_req` stays low.
- R7: A write whose sleep type is 0 to 4, or whose bit 13 is 0, raises no request.
- R8: A write with only `wr_be[0]` set never raises a request, whatever `wr_data[15:8]` holds.
- R9: A write with `wr_be` = 2'b00, or at an offset other than 4 or 5, changes nothing and raises no request. Reads at other offsets return 0.
- R10: Each request is a single-cycle pulse. With no qualifying write in the previous cycle, all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this cycle |
| addr | input | 4 | Byte offset in the window |
| wr_be | input | 2 | Lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Masked control word, or 0 outside offsets 4 and 5 |
| sys_reset_req | output | 1 | One-cycle system reset request (suspend-to-RAM) |
| s3_resume_flag | output | 1 | One-cycle flag marking a suspend-to-RAM resume |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
Embedded properties check on every cycle that the write-only bits read as zero, that the reset and shutdown requests never coincide, and that a request only follows a qualifying high-lane write. They also check that low-lane-only writes, unenabled writes and off-window writes leave the requests low and the word unchanged. The exact mapping of each sleep-type code to its request, the byte-lane merge values and the reset value depend on specific data patterns. Only the directed scenarios, which compare read-back words and pulse timing against values computed in the bench, can show those.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int CTL_W      = 16;
  localparam int LANE_W     = 8;
  localparam int LANES      = CTL_W / LANE_W;
  localparam int SLP_EN_BIT = 13;
  localparam int GLR_BIT    = 2;
  localparam int TYP_LO     = 10;
  localparam int TYP_W      = 3;
  localparam logic [CTL_W-1:0] CTL_RST = 16'h0001;

  localparam logic [TYP_W-1:0] TYP_SUSPEND = 3'd5;
  localparam logic [TYP_W-1:0] TYP_HIBER   = 3'd6;
  localparam logic [TYP_W-1:0] TYP_OFF     = 3'd7;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SUSPEND,
    ACT_POWER_OFF
  } sleep_act_t;

  function automatic sleep_act_t decode_type(input logic [TYP_W-1:0] t);
    sleep_act_t a;
    unique case (t)
      TYP_SUSPEND:       a = ACT_SUSPEND;
      TYP_HIBER, TYP_OFF: a = ACT_POWER_OFF;
      default:           a = ACT_NONE;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/pm1_store.sv
module pm1_store #(
  parameter int W       = 16,
  parameter int LANE_W  = 8,
  parameter int CLR_BIT = 13,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [W/LANE_W-1:0]  lane_en,
  input  logic [W-1:0]         d,
  output logic [W-1:0]         q
);
  localparam int NL = W / LANE_W;
  localparam logic [W-1:0] KEEP = ~(W'(1) << CLR_BIT);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g*LANE_W +: LANE_W] <= RST_VAL[g*LANE_W +: LANE_W] & KEEP[g*LANE_W +: LANE_W];
      else if (we && lane_en[g])
        q[g*LANE_W +: LANE_W] <= d[g*LANE_W +: LANE_W] & KEEP[g*LANE_W +: LANE_W];
    end
  end

  AST_TRIGGER_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !q[CLR_BIT]) else $error("trigger bit stored"); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (|lane_en)) |=> $stable(q)) else $error("word moved without write"); // R9
endmodule

// File: rtl/pm1_sleep_decode.sv
module pm1_sleep_decode
  import pm1_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [TYP_W-1:0] typ,
  output logic             rst_req,
  output logic             s3_flag,
  output logic             off_req
);
  sleep_act_t act;

  always_comb act = fire ? decode_type(typ) : ACT_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      s3_flag <= 1'b0;
      off_req <= 1'b0;
    end else begin
      rst_req <= (act == ACT_SUSPEND);
      s3_flag <= (act == ACT_SUSPEND);
      off_req <= (act == ACT_POWER_OFF);
    end
  end

  AST_PULSE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !(rst_req || s3_flag || off_req)) else $error("request without trigger"); // R10
  AST_SUSPEND_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(typ) == TYP_SUSPEND) else $error("reset request on wrong type"); // R5
endmodule

// File: rtl/pm1_read_mask.sv
module pm1_read_mask #(
  parameter int W = 16,
  parameter logic [W-1:0] HIDE = '0
) (
  input  logic         sel,
  input  logic [W-1:0] word,
  output logic [W-1:0] rd
);
  always_comb rd = sel ? (word & ~HIDE) : '0;
endmodule

// File: rtl/pm1_ctl_reg.sv
module pm1_ctl_reg
  import pm1_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [CTL_W-1:0]  wr_data,
  output logic [CTL_W-1:0]  rd_data,
  output logic              sys_reset_req,
  output logic              s3_resume_flag,
  output logic              shutdown_req
);
  localparam logic [ADDR_W-2:0] HIT_TAG = (ADDR_W-1)'(BASE_OFF / 2);
  localparam logic [CTL_W-1:0]  HIDE    = (CTL_W'(1) << SLP_EN_BIT) | (CTL_W'(1) << GLR_BIT);

  logic             hit;
  logic             wr_hit;
  logic             fire;
  logic [CTL_W-1:0] ctl_q;

  assign hit    = (addr[ADDR_W-1:1] == HIT_TAG);
  assign wr_hit = wr_en && hit;
  assign fire   = wr_hit && wr_be[LANES-1] && wr_data[SLP_EN_BIT];

  pm1_store #(
    .W(CTL_W), .LANE_W(LANE_W), .CLR_BIT(SLP_EN_BIT), .RST_VAL(CTL_RST)
  ) i_store (
    .clk(clk), .rst_n(rst_n), .we(wr_hit), .lane_en(wr_be), .d(wr_data), .q(ctl_q)
  );

  pm1_sleep_decode i_decode (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .typ(wr_data[TYP_LO +: TYP_W]),
    .rst_req(sys_reset_req), .s3_flag(s3_resume_flag), .off_req(shutdown_req)
  );

  pm1_read_mask #(.W(CTL_W), .HIDE(HIDE)) i_mask (
    .sel(hit), .word(ctl_q), .rd(rd_data)
  );

  AST_WO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[SLP_EN_BIT] && !rd_data[GLR_BIT]) else $error("write-only bit visible"); // R4
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_reset_req && shutdown_req)) else $error("both requests high"); // R6
  AST_LOW_LANE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 2'b01) |=> !(sys_reset_req || shutdown_req)) else $error("low lane fired"); // R8
  AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(ctl_q) && !sys_reset_req && !shutdown_req)) else $error("off-window write acted"); // R9
endmodule

// File: tb/test_pm1_ctl_reg.sv
module test_pm1_ctl_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd4;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sys_reset_req, s3_resume_flag, shutdown_req;

  int n_run = 0;
  int n_fail = 0;
  logic p_rst, p_s3, p_sd, q_rst, q_s3, q_sd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm1_ctl_reg i_pm1_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .sys_reset_req(sys_reset_req),
    .s3_resume_flag(s3_resume_flag), .shutdown_req(shutdown_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    p_rst = sys_reset_req; p_s3 = s3_resume_flag; p_sd = shutdown_req;
    wr_en = 1'b0; wr_be = 2'b00;
    @(negedge clk);
    q_rst = sys_reset_req; q_s3 = s3_resume_flag; q_sd = shutdown_req;
  endtask

  task automatic read_at(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic expect_pulses(input string req, input logic r, input logic s, input logic sd);
    check({req, " reset pulse"},    {15'd0, p_rst}, {15'd0, r});
    check({req, " s3 flag pulse"},  {15'd0, p_s3},  {15'd0, s});
    check({req, " shutdown pulse"}, {15'd0, p_sd},  {15'd0, sd});
    check("R10 pulses end", {13'd0, q_rst, q_s3, q_sd}, 16'd0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    read_at(4'd4, v);
    check("R1 reset word", v, 16'h0001);
    check("R1 outputs idle", {13'd0, sys_reset_req, s3_resume_flag, shutdown_req}, 16'd0);
  endtask

  task automatic t_word;
    logic [15:0] v;
    do_write(4'd4, 2'b11, 16'hC0F5);
    expect_pulses("R7 type 0", 1'b0, 1'b0, 1'b0);
    read_at(4'd4, v);
    check("R2/R4 word write masked read", v, 16'hC0F1);
  endtask

  task automatic t_lanes;
    logic [15:0] v;
    do_write(4'd4, 2'b01, 16'h00AA);
    expect_pulses("R8 low lane", 1'b0, 1'b0, 1'b0);
    read_at(4'd5, v);
    check("R3 low lane only", v, 16'hC0AA);
    do_write(4'd5, 2'b10, 16'h12FF);
    expect_pulses("R7 no enable", 1'b0, 1'b0, 1'b0);
    read_at(4'd4, v);
    check("R3 high lane only", v, 16'h12AA);
    do_write(4'd4, 2'b01, 16'hFFFF);
    expect_pulses("R8 low lane with trigger in data", 1'b0, 1'b0, 1'b0);
    read_at(4'd4, v);
    check("R8 low lane store", v, 16'h12FB);
  endtask

  task automatic t_suspend;
    logic [15:0] v;
    do_write(4'd4, 2'b11, 16'h3401);
    expect_pulses("R5 suspend", 1'b1, 1'b1, 1'b0);
    read_at(4'd4, v);
    check("R2 trigger not stored", v, 16'h1401);
  endtask

  task automatic t_off;
    logic [15:0] v;
    do_write(4'd5, 2'b10, 16'h3800);
    expect_pulses("R6 type 6 high lane", 1'b0, 1'b0, 1'b1);
    read_at(4'd4, v);
    check("R6 store after type 6", v, 16'h1801);
    do_write(4'd4, 2'b11, 16'h3C00);
    expect_pulses("R6 type 7", 1'b0, 1'b0, 1'b1);
    read_at(4'd4, v);
    check("R6 store after type 7", v, 16'h1C00);
  endtask

  task automatic t_other;
    logic [15:0] v;
    do_write(4'd4, 2'b11, 16'h2C00);
    expect_pulses("R7 type 3", 1'b0, 1'b0, 1'b0);
    do_write(4'd4, 2'b11, 16'h1400);
    expect_pulses("R7 suspend type without enable", 1'b0, 1'b0, 1'b0);
    read_at(4'd4, v);
    check("R7 store", v, 16'h1400);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    do_write(4'd4, 2'b00, 16'hFFFF);
    expect_pulses("R9 no lanes", 1'b0, 1'b0, 1'b0);
    do_write(4'd6, 2'b11, 16'h3401);
    expect_pulses("R9 off window", 1'b0, 1'b0, 1'b0);
    read_at(4'd4, v);
    check("R9 word unchanged", v, 16'h1400);
    read_at(4'd6, v);
    check("R9 read offset 6", v, 16'h0000);
    read_at(4'd0, v);
    check("R9 read offset 0", v, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_lanes();
    t_suspend();
    t_off();
    t_other();
    t_ignored();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule